// File: doc/BRIEF.md
# VME Slave Address Decoder

This block sits at the front of a VME slave card. For every bus cycle it examines the address-modifier code and the address. It then decides whether the cycle belongs to this card and, if it does, which of four access spaces it falls in: the configuration space, the 16-bit-address register space, the 24-bit-address memory space, or the 32-bit-address block-read space. Downstream register and memory logic receives a registered hit flag, a two-bit space code and the byte offset below the compared address field.

The card's placement in the three data spaces is set by a five-bit base field. This field lives in a writable configuration word. On reset the field loads from the slot's geographic address pins, so a card in slot N starts at a predictable location. The configuration space is always located by the geographic pins, never by the programmable base. Software can therefore find and re-program a card before its base is set. The block serves the configuration space itself: two constant identity words and the base word, read through a 16-bit data path.

Top module: `vme_slot_decoder`

## Requirements
- R1: While reset is asserted, the base field loads from `ga` and `hit` is 0. After reset, a read of configuration offset 0x0004 returns `{ga, 3'b000, 8'h00}`.
- R2: Modifier 0x29 hits when addr[15:11] equals the base field. It gives space code 1 and offset addr[10:0], for both reads and writes.
- R3: Modifier 0x39 hits when addr[23:19] equals the base field. It gives space code 2 and offset addr[18:0], for both reads and writes.
- R4: Modifier 0x0B hits only on a read with addr[31:27] equal to the base field, giving space code 3 and offset addr[26:0]. A write with modifier 0x0B never hits.
- R5: Any modifier other than 0x37, 0x29, 0x39 and 0x0B gives `hit` = 0 and `rdata` = 0.
- R6: Modifier 0x37 hits when addr[23:19] equals `ga`, whatever the base field holds. It gives space code 0 and offset addr[18:0].
- R7: A configuration read at offset 0x0000 returns 16'hA600: vendor code in bits 15:8, zero in bits 7:0.
- R8: A configuration read at offset 0x0002 returns bit 15 = 0, the 7-bit module ID in bits 14:8 and the 8-bit revision in bits 7:0.
- R9: A configuration write at offset 0x0004 copies wdata[15:11] into the base field. Later reads of that offset return bits 10:0 as zero, whatever value was written.
- R10: The outputs are registered. They reflect the cycle presented one clock earlier, and `hit` is 0 after any clock at which `cyc_valid` was low.
- R11: A configuration read at any other offset returns 0. A configuration write at any offset other than 0x0004 leaves the base field unchanged. `rdata` is 0 for every cycle that is not a configuration read hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ga | input | 5 | Geographic slot address |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| am | input | 6 | Address-modifier code |
| addr | input | 32 | Bus address |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| wdata | input | 16 | Write data for the configuration space |
| hit | output | 1 | Cycle belongs to this card |
| space | output | 2 | 0 config, 1 A16 register, 2 A24 memory, 3 A32 block read |
| offset | output | 27 | Byte offset below the compared field |
| rdata | output | 16 | Configuration read data |

## Verification
On every cycle the assertions check that a hit only ever follows a valid cycle with one of the four accepted modifiers. They also check that a block-read hit never comes from a write, that a configuration hit always matches the slot pins, and that read data only appears on a configuration read hit. Some behaviour only the bench's scenarios can show: that the right base field is compared in each space, the exact offsets, the identity words, and that a base written through the configuration word moves the data spaces but not the configuration space. The bench shows these by re-programming the base and then sweeping matching and mismatching addresses.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

   typedef enum logic [1:0] {
      SP_CFG = 2'd0,
      SP_REG = 2'd1,
      SP_MEM = 2'd2,
      SP_BLK = 2'd3
   } space_e;

   localparam int NUM_SPACES = 4;
   localparam int AM_W       = 6;
   localparam int CFG_DW     = 16;

   // modifier code that opens each space, indexed by space code
   function automatic logic [AM_W-1:0] am_code(input int s);
      case (s)
         0:       return 6'h37;
         1:       return 6'h29;
         2:       return 6'h39;
         default: return 6'h0B;
      endcase
   endfunction

   // topmost address bit of the compared field in each space
   function automatic int field_top(input int s);
      case (s)
         0:       return 23;
         1:       return 15;
         2:       return 23;
         default: return 31;
      endcase
   endfunction

endpackage

// File: rtl/vsd_base_reg.sv
module vsd_base_reg #(
   parameter int BASE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] ga,
   input  logic              wr_stb,
   input  logic [BASE_W-1:0] wr_val,
   output logic [BASE_W-1:0] base
);

   always_ff @(posedge clk) begin
      if (!rst_n)      base <= ga;
      else if (wr_stb) base <= wr_val;
   end

endmodule

// File: rtl/vsd_window.sv
module vsd_window
   import vsd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BASE_W = 5,
   localparam int OFF_W = ADDR_W - BASE_W
) (
   input  logic [AM_W-1:0]   am,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [BASE_W-1:0] base,
   input  logic [BASE_W-1:0] ga,
   output logic [NUM_SPACES-1:0] match,
   output logic [OFF_W-1:0]  off [NUM_SPACES]
);

   for (genvar s = 0; s < NUM_SPACES; s++) begin : g_sp
      localparam int TOP = field_top(s);
      localparam int LSB = TOP - BASE_W + 1;
      logic [BASE_W-1:0] fld;
      logic [BASE_W-1:0] ref_val;
      logic              dir_ok;

      assign fld = addr[TOP:LSB];

      if (s == 0) begin : g_geo
         assign ref_val = ga;
      end else begin : g_prog
         assign ref_val = base;
      end

      if (s == 3) begin : g_rd_only
         assign dir_ok = !wr;
      end else begin : g_rw
         assign dir_ok = 1'b1;
      end

      assign match[s] = (am == am_code(s)) && (fld == ref_val) && dir_ok;

      if (LSB == OFF_W) begin : g_full
         assign off[s] = addr[LSB-1:0];
      end else begin : g_pad
         assign off[s] = {{(OFF_W-LSB){1'b0}}, addr[LSB-1:0]};
      end
   end

endmodule

// File: rtl/vsd_cfg_rom.sv
module vsd_cfg_rom
   import vsd_pkg::*;
#(
   parameter int         BASE_W  = 5,
   parameter int         OFF_W   = 27,
   parameter logic [7:0] VENDOR  = 8'hA6,
   parameter logic [6:0] MOD_ID  = 7'h01,
   parameter logic [7:0] MOD_REV = 8'h01
) (
   input  logic [OFF_W-1:0]  off,
   input  logic [BASE_W-1:0] base,
   output logic [CFG_DW-1:0] word
);

   localparam int PAD_W = 8 - BASE_W;

   logic [7:0] base_byte;

   if (PAD_W == 0) begin : g_nopad
      assign base_byte = base;
   end else begin : g_pad
      assign base_byte = {base, {PAD_W{1'b0}}};
   end

   always_comb begin
      case (off)
         OFF_W'(0): word = {VENDOR, 8'h00};
         OFF_W'(2): word = {1'b0, MOD_ID, MOD_REV};
         OFF_W'(4): word = {base_byte, 8'h00};
         default:   word = '0;
      endcase
   end

endmodule

// File: rtl/vme_slot_decoder.sv
module vme_slot_decoder
   import vsd_pkg::*;
#(
   parameter int         ADDR_W  = 32,
   parameter int         BASE_W  = 5,
   parameter logic [7:0] VENDOR  = 8'hA6,
   parameter logic [6:0] MOD_ID  = 7'h01,
   parameter logic [7:0] MOD_REV = 8'h01,
   localparam int        OFF_W   = ADDR_W - BASE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] ga,
   input  logic              cyc_valid,
   input  logic [AM_W-1:0]   am,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [CFG_DW-1:0] wdata,
   output logic              hit,
   output logic [1:0]        space,
   output logic [OFF_W-1:0]  offset,
   output logic [CFG_DW-1:0] rdata
);

   if (ADDR_W != 32) begin : g_chk_aw
      $error("vme_slot_decoder: ADDR_W must be 32");
   end
   if (BASE_W < 1 || BASE_W > 8) begin : g_chk_bw
      $error("vme_slot_decoder: BASE_W must be 1..8");
   end

   logic [NUM_SPACES-1:0] match;
   logic [OFF_W-1:0]      off [NUM_SPACES];
   logic [BASE_W-1:0]     base;
   logic [CFG_DW-1:0]     cfg_word;
   logic                  any_hit;
   space_e                sel;
   logic [OFF_W-1:0]      sel_off;
   logic                  csr_wr;

   vsd_window #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_win (
      .am    (am),
      .addr  (addr),
      .wr    (wr),
      .base  (base),
      .ga    (ga),
      .match (match),
      .off   (off)
   );

   always_comb begin
      any_hit = 1'b0;
      sel     = SP_CFG;
      sel_off = '0;
      for (int s = 0; s < NUM_SPACES; s++) begin
         if (match[s] && !any_hit) begin
            any_hit = 1'b1;
            sel     = space_e'(s);
            sel_off = off[s];
         end
      end
      any_hit = any_hit && cyc_valid;
   end

   assign csr_wr = cyc_valid && match[0] && wr && (off[0] == OFF_W'(4));

   vsd_base_reg #(.BASE_W(BASE_W)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .ga     (ga),
      .wr_stb (csr_wr),
      .wr_val (wdata[CFG_DW-1 -: BASE_W]),
      .base   (base)
   );

   vsd_cfg_rom #(
      .BASE_W (BASE_W),
      .OFF_W  (OFF_W),
      .VENDOR (VENDOR),
      .MOD_ID (MOD_ID),
      .MOD_REV(MOD_REV)
   ) u_rom (
      .off  (off[0]),
      .base (base),
      .word (cfg_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit    <= 1'b0;
         space  <= 2'd0;
         offset <= '0;
         rdata  <= '0;
      end else begin
         hit    <= any_hit;
         space  <= any_hit ? sel : 2'd0;
         offset <= any_hit ? sel_off : '0;
         rdata  <= (any_hit && sel == SP_CFG && !wr) ? cfg_word : '0;
      end
   end

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [4:0]  ga,
   input logic        cyc_valid,
   input logic [5:0]  am,
   input logic [31:0] addr,
   input logic        wr,
   input logic        hit,
   input logic [1:0]  space,
   input logic [15:0] rdata
);

   // R10: no hit unless a cycle was presented at the previous clock
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cyc_valid) |-> !hit);

   // R5: a hit only follows one of the four accepted modifiers
   a_r5_known_am: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ($past(am) == 6'h37 || $past(am) == 6'h29 ||
               $past(am) == 6'h39 || $past(am) == 6'h0B));

   // R4: block-read space never taken by a write
   a_r4_blk_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && space == 2'd3) |-> !$past(wr));

   // R6: configuration hit tracks the slot pins
   a_r6_cfg_geo: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && space == 2'd0) |-> ($past(addr[23:19]) == $past(ga)));

   // R11: read data only on a configuration read hit
   a_r11_rdata_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata != 16'h0) |-> (hit && space == 2'd0 && !$past(wr)));

endmodule

bind vme_slot_decoder vsd_checker u_vsd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ga        (ga),
   .cyc_valid (cyc_valid),
   .am        (am),
   .addr      (addr),
   .wr        (wr),
   .hit       (hit),
   .space     (space),
   .rdata     (rdata)
);

// File: tb/vme_slot_decoder_bench.sv
module vme_slot_decoder_bench;

   localparam logic [4:0] GA  = 5'b10110;
   localparam logic [6:0] MID = 7'h2C;
   localparam logic [7:0] REV = 8'h17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_valid = 1'b0;
   logic [5:0]  am = '0;
   logic [31:0] addr = '0;
   logic        wr = 1'b0;
   logic [15:0] wdata = '0;
   logic        hit;
   logic [1:0]  space;
   logic [26:0] offset;
   logic [15:0] rdata;

   int total = 0;
   int bad   = 0;
   logic [4:0] mbase;

   always #4 clk = ~clk;

   vme_slot_decoder #(.MOD_ID(MID), .MOD_REV(REV)) u_vme_slot_decoder (
      .clk(clk), .rst_n(rst_n), .ga(GA), .cyc_valid(cyc_valid), .am(am),
      .addr(addr), .wr(wr), .wdata(wdata), .hit(hit), .space(space),
      .offset(offset), .rdata(rdata)
   );

   // expected {hit, space, offset, rdata}
   function automatic logic [45:0] model(input logic [5:0] a, input logic [31:0] ad,
                                          input logic w, input logic [4:0] b);
      logic h; logic [1:0] sp; logic [26:0] of; logic [15:0] rd;
      h = 0; sp = 0; of = 0; rd = 0;
      if (a == 6'h37 && ad[23:19] == GA) begin h = 1; sp = 0; of = {8'h0, ad[18:0]}; end
      else if (a == 6'h29 && ad[15:11] == b) begin h = 1; sp = 1; of = {16'h0, ad[10:0]}; end
      else if (a == 6'h39 && ad[23:19] == b) begin h = 1; sp = 2; of = {8'h0, ad[18:0]}; end
      else if (a == 6'h0B && !w && ad[31:27] == b) begin h = 1; sp = 3; of = ad[26:0]; end
      if (h && sp == 0 && !w) begin
         if (of == 0)      rd = 16'hA600;
         else if (of == 2) rd = {1'b0, MID, REV};
         else if (of == 4) rd = {b, 11'h0};
      end
      return {h, sp, of, rd};
   endfunction

   task automatic check(input string req, input logic [45:0] act, input logic [45:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input string req, input logic [5:0] a, input logic [31:0] ad,
                      input logic w, input logic [15:0] d);
      logic [45:0] exp;
      @(negedge clk);
      cyc_valid = 1; am = a; addr = ad; wr = w; wdata = d;
      exp = model(a, ad, w, mbase);
      if (exp[45] && exp[44:43] == 0 && w && exp[42:16] == 27'd4) mbase = d[15:11];
      @(posedge clk); #1;
      check(req, {hit, space, offset, rdata}, exp);
      @(negedge clk);
      cyc_valid = 0;
   endtask

   function automatic logic [31:0] place(input int sp, input logic [4:0] f, input logic [31:0] r);
      logic [31:0] v; v = r;
      case (sp)
         1: v[15:11] = f;
         3: v[31:27] = f;
         default: v[23:19] = f;
      endcase
      return v;
   endfunction

   initial begin
      #1600000;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      mbase = GA;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset hit", {45'h0, hit}, 46'h0);
      @(negedge clk); rst_n = 1;
      cyc("R1 base reset value", 6'h37, place(0, GA, 32'h4), 0, 0);
      cyc("R7 vendor word", 6'h37, place(0, GA, 32'h0), 0, 0);
      cyc("R8 identity word", 6'h37, place(0, GA, 32'h2), 0, 0);
      cyc("R11 unused cfg offset", 6'h37, place(0, GA, 32'h6), 0, 0);
      cyc("R2 reg space hit", 6'h29, place(1, GA, 32'h0000_07FC), 1, 0);
      cyc("R3 mem space hit", 6'h39, place(2, GA, 32'h0007_FFF0), 0, 0);
      cyc("R4 blk read hit", 6'h0B, place(3, GA, 32'h0123_4568), 0, 0);
      cyc("R4 blk write ignored", 6'h0B, place(3, GA, 32'h0000_0100), 1, 0);
      cyc("R5 unknown modifier", 6'h3D, place(2, GA, 32'h0), 0, 0);
      cyc("R11 write elsewhere", 6'h37, place(0, GA, 32'h0), 1, 16'h5800);
      cyc("R11 base kept", 6'h37, place(0, GA, 32'h4), 0, 0);
      cyc("R9 base write", 6'h37, place(0, GA, 32'h4), 1, 16'h4FFF);
      cyc("R9 base readback", 6'h37, place(0, GA, 32'h4), 0, 0);
      cyc("R6 cfg ignores base", 6'h37, place(0, GA, 32'h0), 0, 0);
      cyc("R6 cfg at base misses", 6'h37, place(0, 5'b01001, 32'h0), 0, 0);
      cyc("R2 new base", 6'h29, place(1, 5'b01001, 32'h3), 0, 0);
      cyc("R3 old base misses", 6'h39, place(2, GA, 32'h0), 0, 0);
      @(posedge clk); #1;
      check("R10 idle no hit", {45'h0, hit}, 46'h0);
      for (int i = 0; i < 600; i++) begin
         int k; logic [5:0] a; logic [31:0] r; int sp; logic w;
         k = $urandom_range(0, 5);
         r = $urandom;
         w = $urandom_range(0, 1);
         case (k)
            0: a = 6'h37; 1: a = 6'h29; 2: a = 6'h39; 3: a = 6'h0B;
            default: a = 6'($urandom);
         endcase
         sp = (a == 6'h29) ? 1 : (a == 6'h0B) ? 3 : (a == 6'h37) ? 0 : 2;
         if ($urandom_range(0, 3) != 0) r = place(sp, (sp == 0) ? GA : mbase, r);
         if (a == 6'h37 && $urandom_range(0, 1) == 1) r[18:0] = 19'($urandom_range(0, 3) * 2);
         cyc("R2 R3 R4 R5 R6 R9 random", a, r, w, 16'($urandom));
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule